// File: doc/BRIEF.md
# Dual-Writer Register Field

This block is one storage field of a control/status register that two agents can update: software, through a write strobe with a data bus and one enable per byte lane, and on-chip hardware, through a data input and a write enable. Elaboration parameters decide whether each side may write at all, which polarity the hardware enable has (or whether hardware loads every cycle), and which side wins when both write on the same clock edge.

The stored value is always visible on `field_o`. Three optional single-bit outputs carry the AND, OR and XOR of all stored bits, each one enabled separately. Address decoding, read-back selection and bus handshakes are done outside this block; the field sees only an already-decoded write strobe.

Top module: `regfld_field`

## Requirements
- R1: During a synchronous reset (reset polarity chosen by `RST_ACTIVE_LOW`, default low) the field loads `RESET_VALUE`; with `HAS_RESET_VALUE` = 0 reset leaves the content undefined.
- R2: A software write (`sw_wr_i` = 1, software writable) changes byte lane i, bits 8*i+7..8*i, to the same bits of `sw_wdata_i` only when `sw_be_i[i]` = 1; lanes whose enable is 0 keep their value.
- R3: The field has ceil(`WIDTH`/8) byte enables; when `WIDTH` is not a multiple of 8 the top enable covers only the remaining upper bits (for `WIDTH` = 20, `sw_be_i[2]` covers bits 19..16).
- R4: Hardware loads `hw_wdata_i` when `hw_we_i` equals its configured active level (1 for active-high mode, 0 for active-low mode), and on every cycle when the enable-free mode is chosen.
- R5: With software precedence (default), when software and hardware write in the same cycle the software write is applied and the hardware value is dropped, even when every `sw_be_i` bit is 0.
- R6: With hardware precedence, a hardware write in a cycle blocks any software write in that cycle and the field takes `hw_wdata_i`.
- R7: In a cycle with no enabled write from either side the field keeps its value.
- R8: A side whose access mode is neither write-only nor read-write has no effect on the field.
- R9: The AND, OR and XOR outputs are reductions of the stored value, valid in the cycle after the write that set it.
- R10: A reduction output that is not enabled by its parameter stays at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, polarity set by `RST_ACTIVE_LOW` |
| sw_wr_i | input | 1 | Decoded software write strobe |
| sw_be_i | input | ceil(WIDTH/8) | Software byte-lane enables |
| sw_wdata_i | input | WIDTH | Software write data |
| hw_we_i | input | 1 | Hardware write enable, polarity set by `HW_EN_MODE` |
| hw_wdata_i | input | WIDTH | Hardware write data |
| field_o | output | WIDTH | Stored field value |
| and_o | output | 1 | AND of all stored bits (0 when disabled) |
| or_o | output | 1 | OR of all stored bits (0 when disabled) |
| xor_o | output | 1 | XOR of all stored bits (0 when disabled) |

## Verification
All state of this block sits in one register that is wired straight to `field_o`, so any wrong lane update, wrong arbitration winner or missed hold shows on the port one clock edge after the offending cycle and stays there until the next write. A wrong reduction appears combinationally in the same cycle as the stored value it belongs to. The directed cases therefore sample every output half a period after each edge and aim stimulus at the cycles where a mistake would be visible: simultaneous writes, zero byte enables, the partial top lane and both enable polarities.

// File: rtl/regfld_pkg.sv
// Package: shared types and helpers for the dual-writer register field.
// Assumes: access modes and enable modes are elaboration-time constants.
package regfld_pkg;

    // Access permission of one writer side.
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_RO   = 2'd1,
        ACC_WO   = 2'd2,
        ACC_RW   = 2'd3
    } access_e;

    // How the hardware write enable is interpreted.
    typedef enum logic [1:0] {
        HWEN_ALWAYS = 2'd0,
        HWEN_HIGH   = 2'd1,
        HWEN_LOW    = 2'd2
    } hw_en_mode_e;

    // True when the access mode grants a write path.
    function automatic logic may_write(access_e acc);
        return (acc == ACC_WO) || (acc == ACC_RW);
    endfunction

    // Number of byte lanes needed to cover a field of the given width.
    function automatic int lane_count(int width);
        return (width + 7) / 8;
    endfunction

endpackage

// File: rtl/regfld_lane.sv
// Module: one software byte lane merge.
// Picks the new lane bits when the lane enable is set, else keeps the
// current bits. Assumes LANE_W is 1..8.
module regfld_lane #(
    parameter int LANE_W = 8
) (
    input  logic              en_i,
    input  logic [LANE_W-1:0] cur_i,
    input  logic [LANE_W-1:0] wdata_i,
    output logic [LANE_W-1:0] nxt_o
);

    // Lane select between stored and written bits.
    always_comb begin
        nxt_o = en_i ? wdata_i : cur_i;
    end

endmodule

// File: rtl/regfld_sw_path.sv
// Module: software write path.
// Builds the byte-merged next value from the current field and raises a
// request when software may write and the strobe is set. Assumes the
// strobe is already address-decoded.
module regfld_sw_path
    import regfld_pkg::*;
#(
    parameter int      WIDTH     = 20,
    parameter access_e SW_ACCESS = ACC_RW,
    localparam int     NLANES    = (WIDTH + 7) / 8
) (
    input  logic              sw_wr_i,
    input  logic [NLANES-1:0] sw_be_i,
    input  logic [WIDTH-1:0]  sw_wdata_i,
    input  logic [WIDTH-1:0]  cur_i,
    output logic              req_o,
    output logic [WIDTH-1:0]  next_o
);

    localparam logic CAN_WRITE = may_write(SW_ACCESS);

    // Request only exists when the access mode grants a write path.
    always_comb begin
        req_o = CAN_WRITE && sw_wr_i;
    end

    // One merge cell per byte lane; the top lane may be narrower than 8.
    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        localparam int LO = 8 * g;
        localparam int LW = ((WIDTH - LO) < 8) ? (WIDTH - LO) : 8;

        regfld_lane #(
            .LANE_W (LW)
        ) u_lane (
            .en_i    (sw_be_i[g]),
            .cur_i   (cur_i[LO +: LW]),
            .wdata_i (sw_wdata_i[LO +: LW]),
            .nxt_o   (next_o[LO +: LW])
        );
    end

endmodule

// File: rtl/regfld_hw_path.sv
// Module: hardware write request decode.
// Turns the hardware enable into a request according to the configured
// polarity mode. Assumes modes are constants.
module regfld_hw_path
    import regfld_pkg::*;
#(
    parameter access_e     HW_ACCESS  = ACC_RW,
    parameter hw_en_mode_e HW_EN_MODE = HWEN_LOW
) (
    input  logic hw_we_i,
    output logic req_o
);

    localparam logic CAN_WRITE = may_write(HW_ACCESS);

    logic en_active;

    // Interpret the enable according to its polarity mode.
    always_comb begin
        case (HW_EN_MODE)
            HWEN_HIGH: en_active = hw_we_i;
            HWEN_LOW:  en_active = !hw_we_i;
            default:   en_active = 1'b1;
        endcase
    end

    // Request only exists when the access mode grants a write path.
    always_comb begin
        req_o = CAN_WRITE && en_active;
    end

endmodule

// File: rtl/regfld_arbiter.sv
// Module: write-source arbitration.
// Chooses between software and hardware data when both request; the
// precedence is fixed at elaboration. Assumes sw_next already holds the
// unwritten lanes at their current value.
module regfld_arbiter #(
    parameter int WIDTH       = 20,
    parameter bit HW_PRIORITY = 1'b0
) (
    input  logic             sw_req_i,
    input  logic [WIDTH-1:0] sw_next_i,
    input  logic             hw_req_i,
    input  logic [WIDTH-1:0] hw_data_i,
    output logic             wr_en_o,
    output logic [WIDTH-1:0] wr_data_o
);

    // Any request causes a load.
    always_comb begin
        wr_en_o = sw_req_i || hw_req_i;
    end

    if (HW_PRIORITY) begin : g_hw_first
        // Hardware first, software only when hardware is idle.
        always_comb begin
            wr_data_o = hw_req_i ? hw_data_i : sw_next_i;
        end
    end else begin : g_sw_first
        // Software first, hardware only when software is idle.
        always_comb begin
            wr_data_o = sw_req_i ? sw_next_i : hw_data_i;
        end
    end

endmodule

// File: rtl/regfld_reduce.sv
// Module: optional bitwise reductions of the stored value.
// Each reduction can be enabled on its own; a disabled one drives 0.
// Assumes value_i is the registered field.
module regfld_reduce #(
    parameter int WIDTH  = 20,
    parameter bit EN_AND = 1'b1,
    parameter bit EN_OR  = 1'b1,
    parameter bit EN_XOR = 1'b1
) (
    input  logic [WIDTH-1:0] value_i,
    output logic             and_o,
    output logic             or_o,
    output logic             xor_o
);

    if (EN_AND) begin : g_and
        // AND of all stored bits.
        always_comb begin
            and_o = &value_i;
        end
        // R9: all-ones value and only that value gives 1.
        always_comb begin
            p_and_r9: assert (and_o == ($countones(value_i) == WIDTH));
        end
    end else begin : g_no_and
        // Disabled output held low.
        always_comb begin
            and_o = 1'b0;
        end
    end

    if (EN_OR) begin : g_or
        // OR of all stored bits.
        always_comb begin
            or_o = |value_i;
        end
        // R9: OR is 1 exactly when some bit is set.
        always_comb begin
            p_or_r9: assert (or_o == ($countones(value_i) != 0));
        end
    end else begin : g_no_or
        // Disabled output held low.
        always_comb begin
            or_o = 1'b0;
        end
    end

    if (EN_XOR) begin : g_xor
        // XOR (parity) of all stored bits.
        always_comb begin
            xor_o = ^value_i;
        end
        // R9: parity matches the count of set bits.
        always_comb begin
            p_xor_r9: assert (xor_o == ($countones(value_i) % 2 == 1));
        end
    end else begin : g_no_xor
        // Disabled output held low.
        always_comb begin
            xor_o = 1'b0;
        end
    end

endmodule

// File: rtl/regfld_field.sv
// Module: dual-writer register field (top).
// Stores WIDTH bits written by software (per byte lane) and by hardware,
// arbitrated by a fixed precedence, and exposes optional reductions.
// Assumes synchronous reset and a decoded software strobe.
module regfld_field
    import regfld_pkg::*;
#(
    parameter int               WIDTH           = 20,
    parameter access_e          SW_ACCESS       = ACC_RW,
    parameter access_e          HW_ACCESS       = ACC_RW,
    parameter hw_en_mode_e      HW_EN_MODE      = HWEN_LOW,
    parameter bit               HW_PRIORITY     = 1'b0,
    parameter bit               RST_ACTIVE_LOW  = 1'b1,
    parameter bit               HAS_RESET_VALUE = 1'b1,
    parameter logic [WIDTH-1:0] RESET_VALUE     = 20'h5A3C1,
    parameter bit               EN_AND          = 1'b1,
    parameter bit               EN_OR           = 1'b1,
    parameter bit               EN_XOR          = 1'b1,
    localparam int              NLANES          = (WIDTH + 7) / 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              sw_wr_i,
    input  logic [NLANES-1:0] sw_be_i,
    input  logic [WIDTH-1:0]  sw_wdata_i,
    input  logic              hw_we_i,
    input  logic [WIDTH-1:0]  hw_wdata_i,
    output logic [WIDTH-1:0]  field_o,
    output logic              and_o,
    output logic              or_o,
    output logic              xor_o
);

    logic             rst_act;
    logic             sw_req;
    logic             hw_req;
    logic [WIDTH-1:0] sw_next;
    logic             wr_en;
    logic [WIDTH-1:0] wr_data;
    logic [WIDTH-1:0] field_q;

    // Normalise the reset to an active-high internal level.
    always_comb begin
        rst_act = RST_ACTIVE_LOW ? !rst_i : rst_i;
    end

    regfld_sw_path #(
        .WIDTH     (WIDTH),
        .SW_ACCESS (SW_ACCESS)
    ) u_sw (
        .sw_wr_i    (sw_wr_i),
        .sw_be_i    (sw_be_i),
        .sw_wdata_i (sw_wdata_i),
        .cur_i      (field_q),
        .req_o      (sw_req),
        .next_o     (sw_next)
    );

    regfld_hw_path #(
        .HW_ACCESS  (HW_ACCESS),
        .HW_EN_MODE (HW_EN_MODE)
    ) u_hw (
        .hw_we_i (hw_we_i),
        .req_o   (hw_req)
    );

    regfld_arbiter #(
        .WIDTH       (WIDTH),
        .HW_PRIORITY (HW_PRIORITY)
    ) u_arb (
        .sw_req_i  (sw_req),
        .sw_next_i (sw_next),
        .hw_req_i  (hw_req),
        .hw_data_i (hw_wdata_i),
        .wr_en_o   (wr_en),
        .wr_data_o (wr_data)
    );

    if (HAS_RESET_VALUE) begin : g_rst_val
        // Storage register with a defined reset value.
        always_ff @(posedge clk_i) begin
            if (rst_act) begin
                field_q <= RESET_VALUE;
            end else if (wr_en) begin
                field_q <= wr_data;
            end
        end
    end else begin : g_no_rst_val
        // Storage register whose content is undefined after reset.
        always_ff @(posedge clk_i) begin
            if (!rst_act && wr_en) begin
                field_q <= wr_data;
            end
        end
    end

    // Stored value straight to the port.
    always_comb begin
        field_o = field_q;
    end

    regfld_reduce #(
        .WIDTH  (WIDTH),
        .EN_AND (EN_AND),
        .EN_OR  (EN_OR),
        .EN_XOR (EN_XOR)
    ) u_red (
        .value_i (field_q),
        .and_o   (and_o),
        .or_o    (or_o),
        .xor_o   (xor_o)
    );

    // R7: no request from either side means the value holds.
    p_hold_r7: assert property (@(posedge clk_i) disable iff (rst_act)
        (!sw_req && !hw_req) |=> $stable(field_q));

    if (HW_PRIORITY) begin : g_chk_hw
        // R6: a hardware request always lands its data.
        p_hw_wins_r6: assert property (@(posedge clk_i) disable iff (rst_act)
            hw_req |=> (field_q == $past(hw_wdata_i)));
    end else begin : g_chk_sw
        // R5: on a collision the software merge lands, hardware is dropped.
        p_sw_wins_r5: assert property (@(posedge clk_i) disable iff (rst_act)
            (sw_req && hw_req) |=> (field_q == $past(sw_next)));
    end

endmodule

// File: tb/sim_regfld_field.sv
// Bench: directed scenarios on three configurations sharing stimulus.
// u0: defaults (sw precedence, active-low hw enable, all reductions).
// u1: hw precedence, active-high enable, AND reduction disabled, reset 0.
// u2: software read-only, hardware loads every cycle, reset all ones.
module sim_regfld_field;
    import regfld_pkg::*;

    localparam int W  = 20;
    localparam int NL = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sw_wr;
    logic [NL-1:0] sw_be;
    logic [W-1:0]  sw_wdata;
    logic          we_a;
    logic          we_b;
    logic [W-1:0]  hw_wdata;

    logic [W-1:0] f0, f1, f2;
    logic a0, o0, x0, a1, o1, x1, a2, o2, x2;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = !clk;

    regfld_field u0 (
        .clk_i(clk), .rst_i(rst_n), .sw_wr_i(sw_wr), .sw_be_i(sw_be),
        .sw_wdata_i(sw_wdata), .hw_we_i(we_a), .hw_wdata_i(hw_wdata),
        .field_o(f0), .and_o(a0), .or_o(o0), .xor_o(x0)
    );

    regfld_field #(
        .HW_EN_MODE(HWEN_HIGH), .HW_PRIORITY(1'b1),
        .RESET_VALUE(20'h00000), .EN_AND(1'b0)
    ) u1 (
        .clk_i(clk), .rst_i(rst_n), .sw_wr_i(sw_wr), .sw_be_i(sw_be),
        .sw_wdata_i(sw_wdata), .hw_we_i(we_b), .hw_wdata_i(hw_wdata),
        .field_o(f1), .and_o(a1), .or_o(o1), .xor_o(x1)
    );

    regfld_field #(
        .SW_ACCESS(ACC_RO), .HW_EN_MODE(HWEN_ALWAYS),
        .RESET_VALUE(20'hFFFFF)
    ) u2 (
        .clk_i(clk), .rst_i(rst_n), .sw_wr_i(sw_wr), .sw_be_i(sw_be),
        .sw_wdata_i(sw_wdata), .hw_we_i(1'b0), .hw_wdata_i(hw_wdata),
        .field_o(f2), .and_o(a2), .or_o(o2), .xor_o(x2)
    );

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %05h expected %05h", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, let one rising edge pass, and
    // return at the next falling edge where results are sampled.
    task automatic step(logic wr, logic [NL-1:0] be, logic [W-1:0] sd,
                        logic wa, logic wb, logic [W-1:0] hd);
        sw_wr = wr; sw_be = be; sw_wdata = sd;
        we_a = wa; we_b = wb; hw_wdata = hd;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(logic [W-1:0] hd);
        step(1'b0, 3'b000, 20'h00000, 1'b1, 1'b0, hd);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        idle(20'h00000);
        idle(20'h00000);
        check("R1 u0 reset", f0, 20'h5A3C1);
        check("R1 u1 reset", f1, 20'h00000);
        check("R1 u2 reset", f2, 20'hFFFFF);
        rst_n = 1'b1;
        idle(20'h12345);
        check("R7 u0 hold after reset", f0, 20'h5A3C1);
        check("R7 u1 hold after reset", f1, 20'h00000);
        check("R4 u2 always-load", f2, 20'h12345);
    endtask

    task automatic t_sw_lanes;
        step(1'b1, 3'b010, 20'h98765, 1'b1, 1'b0, 20'h00000);
        check("R2 u0 middle lane only", f0, 20'h587C1);
        check("R2 u1 middle lane only", f1, 20'h08700);
        check("R8 u2 sw read-only ignored", f2, 20'h00000);
    endtask

    task automatic t_top_lane;
        step(1'b1, 3'b100, 20'hE0000, 1'b1, 1'b0, 20'h00000);
        check("R3 u0 partial top lane", f0, 20'hE87C1);
        check("R3 u1 partial top lane", f1, 20'hE8700);
    endtask

    task automatic t_hw_polarity;
        step(1'b0, 3'b000, 20'h00000, 1'b0, 1'b0, 20'h0F0F0);
        check("R4 u0 active-low enable loads", f0, 20'h0F0F0);
        check("R4 u1 low enable on high mode holds", f1, 20'hE8700);
        check("R4 u2 always-load", f2, 20'h0F0F0);
        step(1'b0, 3'b000, 20'h00000, 1'b1, 1'b0, 20'h11111);
        check("R4 u0 inactive enable holds", f0, 20'h0F0F0);
        check("R4 u2 always-load", f2, 20'h11111);
    endtask

    task automatic t_sw_priority;
        step(1'b1, 3'b001, 20'h000AA, 1'b0, 1'b0, 20'h77777);
        check("R5 u0 sw wins collision", f0, 20'h0F0AA);
        check("R2 u1 low lane", f1, 20'hE87AA);
        step(1'b1, 3'b000, 20'hFFFFF, 1'b0, 1'b0, 20'h33333);
        check("R5 u0 zero enables still block hw", f0, 20'h0F0AA);
        check("R2 u1 zero enables change nothing", f1, 20'hE87AA);
        check("R8 u2 follows hw only", f2, 20'h33333);
    endtask

    task automatic t_hw_priority;
        step(1'b1, 3'b111, 20'h55555, 1'b1, 1'b1, 20'h2468A);
        check("R6 u1 hw blocks sw", f1, 20'h2468A);
        check("R2 u0 full sw write", f0, 20'h55555);
        step(1'b0, 3'b000, 20'h00000, 1'b1, 1'b1, 20'hABCDE);
        check("R6 u1 hw alone", f1, 20'hABCDE);
        check("R7 u0 hold", f0, 20'h55555);
    endtask

    task automatic t_reduce;
        check("R9 u0 and before write", {19'd0, a0}, 20'd0);
        check("R9 u0 xor of 55555", {19'd0, x0}, 20'd0);
        step(1'b1, 3'b111, 20'hFFFFF, 1'b1, 1'b1, 20'hFFFFF);
        check("R9 u0 and after all-ones", {19'd0, a0}, 20'd1);
        check("R9 u0 or after all-ones", {19'd0, o0}, 20'd1);
        check("R9 u0 xor after all-ones", {19'd0, x0}, 20'd0);
        check("R10 u1 disabled and stays low", {19'd0, a1}, 20'd0);
        check("R9 u1 or", {19'd0, o1}, 20'd1);
        step(1'b1, 3'b111, 20'h00000, 1'b1, 1'b0, 20'h00000);
        check("R9 u0 or of zero", {19'd0, o0}, 20'd0);
        check("R9 u0 and of zero", {19'd0, a0}, 20'd0);
        step(1'b1, 3'b001, 20'h00001, 1'b1, 1'b0, 20'h00007);
        check("R9 u0 xor single bit", {19'd0, x0}, 20'd1);
        check("R9 u2 xor of 7", {19'd0, x2}, 20'd1);
    endtask

    task automatic t_hold;
        for (int i = 0; i < 4; i++) begin
            idle(20'h00007);
            check("R7 u0 idle hold", f0, 20'h00001);
            check("R7 u1 idle hold", f1, 20'h00001);
        end
    endtask

    initial begin
        rst_n = 1'b0; sw_wr = 1'b0; sw_be = '0; sw_wdata = '0;
        we_a = 1'b1; we_b = 1'b0; hw_wdata = '0;
        @(negedge clk);
        t_reset();
        t_sw_lanes();
        t_top_lane();
        t_hw_polarity();
        t_sw_priority();
        t_hw_priority();
        t_reduce();
        t_hold();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule